// File: doc/BRIEF.md
# Dual-Channel Sampling ADC Read Controller

This block is the host side of a two-channel, simultaneous-sampling converter with a serial output. A one-cycle `start_i` request starts the sequence. The controller drives the conversion strobe low for a fixed number of cycles, which makes the converter sample both channels at once. It then watches the converter's busy flag. Once busy is low, it lowers chip select and generates a divided serial clock that idles high. It captures both results MSB first and presents them together with a one-cycle valid pulse.

Two read modes are available:
- **Two-lane read:** both data lines are shifted in parallel.
- **Chained read on one line:** the chosen line carries its own converter's word and then the other converter's word, with chip select held low throughout.

An early-select option lowers chip select while the conversion is still running, so the MSB is on the line as soon as busy drops. If busy never drops, a timeout returns the controller to idle and raises an error flag.

Result width is a parameter (12 or 14 bits). All timing is counted in system-clock cycles. All inputs are assumed synchronous to `clk_i`.

Top module: `adc_rd_ctrl`

## Requirements
- R1: Out of reset and whenever idle, `ready_o` is 1, `cnv_n_o`, `cs_n_o` and `sclk_o` are all high, and `valid_o` and `err_o` are 0.
- R2: `start_i` sampled high while idle produces exactly one low pulse on `cnv_n_o`, lasting CNV_W cycles. `start_i` is ignored while a transaction is in progress.
- R3: With early select off, `cs_n_o` stays high for as long as `busy_i` is high, and falls only in the cycle after `busy_i` was sampled low.
- R4: With early select on, `cs_n_o` goes low while `busy_i` is still high and stays low into the read.
- R5: In the cycle where `cs_n_o` falls, `sclk_o` is high and unchanged. Each SCLK phase, high or low, lasts SCLK_DIV cycles, so a read with chip select low from the start of the shift spends exactly 2·SCLK_DIV·pulses cycles with `cs_n_o` low.
- R6: With `single_lane_i`=0, exactly RES_W SCLK pulses are produced. `res_a_o` takes the bits from `sdo_a_i` and `res_b_o` takes the bits from `sdo_b_i`, MSB first. Each bit is sampled before the SCLK falling edge that follows it.
- R7: With `single_lane_i`=1, exactly 2·RES_W pulses are produced on one line.
  - `lane_sel_i`=0 uses `sdo_a_i`: the first word goes to `res_a_o` and the second to `res_b_o`.
  - `lane_sel_i`=1 uses `sdo_b_i`: the first word goes to `res_b_o` and the second to `res_a_o`.
- R8: After the last pulse, `cs_n_o` rises and `valid_o` is high for exactly one cycle, in which `ready_o` is 1. Both result words update together in that cycle and hold until the next valid pulse.
- R9: If `busy_i` stays high for BUSY_TIMEOUT cycles of waiting, then:
  - `err_o` is set and the controller returns to idle with no SCLK pulse and no valid pulse;
  - the results keep their old values;
  - `err_o` clears when the next start is accepted.
- R10: `sclk_o` never falls while `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and read, sampled while idle |
| single_lane_i | input | 1 | 1: chained read on one line; 0: two-lane read |
| lane_sel_i | input | 1 | Line used in chained mode (0: A, 1: B) |
| early_cs_i | input | 1 | Lower chip select during the conversion |
| busy_i | input | 1 | Converter busy flag |
| sdo_a_i | input | 1 | Serial data line of converter A |
| sdo_b_i | input | 1 | Serial data line of converter B |
| cnv_n_o | output | 1 | Conversion strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| ready_o | output | 1 | Controller idle |
| valid_o | output | 1 | One-cycle pulse when both results update |
| res_a_o | output | RES_W | Converter A result |
| res_b_o | output | RES_W | Converter B result |
| err_o | output | 1 | Busy timeout flag |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- the idle line levels;
- the strobe leaving only from idle;
- chip select falling only after busy was seen low when early select is off;
- SCLK held high across the chip-select fall, and never falling with chip select high;
- the single-cycle valid pulse;
- the error flag rising only into idle.

Only the bench's scenarios can show the rest:
- that the captured words match what the converter model placed on the lines, in each of the two-lane and chained lane orders;
- that pulse counts and phase lengths are right;
- that early select lowers chip select during busy;
- that a busy timeout leaves the old results intact.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CNV   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] hcnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = (hcnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      hcnt_q <= '0;
      sclk_q <= 1'b1;
    end else if (wrap) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  // fall_o: last cycle of the high phase, data is sampled here
  assign fall_o = run_i && sclk_q && wrap;
  assign rise_o = run_i && !sclk_q && wrap;
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             single_i,
  input  logic             sel_i,
  input  logic             sdo_a_i,
  input  logic             sdo_b_i,
  output logic [RES_W-1:0] word_a_o,
  output logic [RES_W-1:0] word_b_o
);
  localparam int unsigned LW = 2 * RES_W;

  logic [LW-1:0]    lane_x_q;  // chained stream or line A
  logic [RES_W-1:0] lane_y_q;  // line B in two-lane mode
  logic             bit_x;

  assign bit_x = (single_i && sel_i) ? sdo_b_i : sdo_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_x_q <= '0;
      lane_y_q <= '0;
    end else if (sample_i) begin
      lane_x_q <= {lane_x_q[LW-2:0], bit_x};
      lane_y_q <= {lane_y_q[RES_W-2:0], sdo_b_i};
    end
  end

  always_comb begin
    if (!single_i) begin
      word_a_o = lane_x_q[RES_W-1:0];
      word_b_o = lane_y_q;
    end else if (!sel_i) begin
      word_a_o = lane_x_q[LW-1:RES_W];
      word_b_o = lane_x_q[RES_W-1:0];
    end else begin
      word_b_o = lane_x_q[LW-1:RES_W];
      word_a_o = lane_x_q[RES_W-1:0];
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SCLK_DIV     = 2,
  parameter int unsigned CNV_W        = 4,
  parameter int unsigned BUSY_TIMEOUT = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             single_lane_i,
  input  logic             lane_sel_i,
  input  logic             early_cs_i,
  input  logic             busy_i,
  input  logic             sdo_a_i,
  input  logic             sdo_b_i,
  output logic             cnv_n_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             ready_o,
  output logic             valid_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             err_o
);
  localparam int unsigned NB_MAX = 2 * RES_W;
  localparam int unsigned BCW    = $clog2(NB_MAX);

  if (RES_W != 12 && RES_W != 14) begin : g_bad_width
    $error("RES_W must be 12 or 14");
  end

  rd_state_e        state_q;
  logic             single_q, sel_q, early_q;
  logic [BCW-1:0]   bit_q, last_idx;
  logic [RES_W-1:0] res_a_q, res_b_q, word_a, word_b;
  logic             valid_q, err_q;
  logic             cnv_hit, busy_hit, sclk_fall, sclk_rise;
  logic             in_cnv, in_wait, in_shift;

  assign in_cnv   = (state_q == ST_CNV);
  assign in_wait  = (state_q == ST_WAIT);
  assign in_shift = (state_q == ST_SHIFT);
  assign last_idx = single_q ? BCW'(NB_MAX - 1) : BCW'(RES_W - 1);

  adc_rd_timer #(.LIMIT(CNV_W)) u_cnv_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!in_cnv), .en_i(in_cnv), .hit_o(cnv_hit)
  );

  adc_rd_timer #(.LIMIT(BUSY_TIMEOUT)) u_busy_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!in_wait), .en_i(in_wait), .hit_o(busy_hit)
  );

  adc_rd_sclk #(.DIV(SCLK_DIV)) u_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_shift),
    .sclk_o(sclk_o), .fall_o(sclk_fall), .rise_o(sclk_rise)
  );

  adc_rd_shift #(.RES_W(RES_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sclk_fall),
    .single_i(single_q), .sel_i(sel_q),
    .sdo_a_i(sdo_a_i), .sdo_b_i(sdo_b_i),
    .word_a_o(word_a), .word_b_o(word_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
      sel_q    <= 1'b0;
      early_q  <= 1'b0;
      bit_q    <= '0;
      res_a_q  <= '0;
      res_b_q  <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            single_q <= single_lane_i;
            sel_q    <= lane_sel_i;
            early_q  <= early_cs_i;
            err_q    <= 1'b0;
            state_q  <= ST_CNV;
          end
        end
        ST_CNV: begin
          if (cnv_hit) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!busy_i) begin
            bit_q   <= '0;
            state_q <= ST_SHIFT;
          end else if (busy_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (sclk_rise) begin
            if (bit_q == last_idx) begin
              res_a_q <= word_a;
              res_b_q <= word_b;
              valid_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_n_o = !in_cnv;
  assign cs_n_o  = !(in_shift || (in_wait && early_q));
  assign ready_o = (state_q == ST_IDLE);
  assign valid_o = valid_q;
  assign res_a_o = res_a_q;
  assign res_b_o = res_b_q;
  assign err_o   = err_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_n_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic ready_o,
  input logic valid_o,
  input logic err_o,
  input logic busy_i,
  input logic early_q
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cnv_n_o && cs_n_o && sclk_o));

  p_cnv_from_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_n_o) |-> $past(ready_o));

  p_cs_after_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_n_o) && !early_q) |-> !$past(busy_i));

  p_cs_fall_sclk_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (sclk_o && $stable(sclk_o)));

  p_valid_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ready_o && cs_n_o));

  p_err_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (ready_o && !valid_o));

  p_sclk_under_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !cs_n_o);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .ready_o(ready_o), .valid_o(valid_o), .err_o(err_o),
  .busy_i(busy_i), .early_q(early_q)
);

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;
  localparam int RW   = 12;
  localparam int DIV  = 2;
  localparam int CNVW = 4;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0, sel = 1'b0, early = 1'b0;
  logic busy = 1'b0, sdo_a = 1'b0, sdo_b = 1'b0;
  logic cnv_n, cs_n, sclk, ready, valid, err;
  logic [RW-1:0] res_a, res_b;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.RES_W(RW), .SCLK_DIV(DIV), .CNV_W(CNVW), .BUSY_TIMEOUT(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_lane_i(single),
    .lane_sel_i(sel), .early_cs_i(early), .busy_i(busy), .sdo_a_i(sdo_a),
    .sdo_b_i(sdo_b), .cnv_n_o(cnv_n), .cs_n_o(cs_n), .sclk_o(sclk),
    .ready_o(ready), .valid_o(valid), .res_a_o(res_a), .res_b_o(res_b), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  // converter model and monitor, evaluated away from the active edge
  logic [RW-1:0] val_a = '0, val_b = '0, lat_a = '0, lat_b = '0;
  int conv_cycles = 20, busy_cnt = 0, idx = 0;
  logic p_cnv = 1'b1, p_sclk = 1'b1, p_cs = 1'b1;
  int m_cnv_falls, m_cnv_low, m_cs_low, m_cs_busy, m_sclk_falls, m_sclk_hi_falls;
  int m_valid, m_ready_at_valid;
  logic [RW-1:0] m_cap_a, m_cap_b;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_cnt = 0; idx = 0;
    end else begin
      if (p_cnv && !cnv_n) m_cnv_falls++;
      if (!cnv_n) m_cnv_low++;
      if (!cs_n) m_cs_low++;
      if (!cs_n && busy) m_cs_busy++;
      if (p_sclk && !sclk) begin
        if (!cs_n) m_sclk_falls++; else m_sclk_hi_falls++;
      end
      if (valid) begin
        m_valid++; m_ready_at_valid = int'(ready); m_cap_a = res_a; m_cap_b = res_b;
      end
      if (p_cnv && !cnv_n) begin
        busy_cnt = conv_cycles; lat_a = val_a; lat_b = val_b;
      end else if (busy_cnt > 0) busy_cnt--;
      if (cs_n) idx = 0;
      else if (p_sclk && !sclk && !p_cs) idx++;
    end
    busy = (busy_cnt > 0);
    if (!cs_n && idx < 2*RW) begin
      sdo_a = {lat_a, lat_b}[2*RW-1-idx];
      sdo_b = {lat_b, lat_a}[2*RW-1-idx];
    end else begin
      sdo_a = 1'b0; sdo_b = 1'b0;
    end
    p_cnv = cnv_n; p_sclk = sclk; p_cs = cs_n;
  end

  task automatic clear_mon();
    m_cnv_falls = 0; m_cnv_low = 0; m_cs_low = 0; m_cs_busy = 0;
    m_sclk_falls = 0; m_sclk_hi_falls = 0; m_valid = 0; m_ready_at_valid = 0;
  endtask

  task automatic launch(bit sg, bit sl, bit er);
    clear_mon();
    @(posedge clk); #1;
    single = sg; sel = sl; early = er; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (10) @(posedge clk);
    #1 start = 1'b1;                  // must be ignored (R2)
    @(posedge clk); #1 start = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); #1;
      if (m_valid > 0 || err) break;
    end
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic run_xfer(bit sg, bit sl, bit er, logic [RW-1:0] a, logic [RW-1:0] b);
    int nb;
    nb = sg ? 2*RW : RW;
    val_a = a; val_b = b; conv_cycles = 20;
    launch(sg, sl, er);
    check(m_cap_a == a, sg ? "R7 res_a" : "R6 res_a", m_cap_a, a);
    check(m_cap_b == b, sg ? "R7 res_b" : "R6 res_b", m_cap_b, b);
    check(m_sclk_falls == nb, sg ? "R7 pulses" : "R6 pulses", m_sclk_falls, nb);
    check(m_sclk_hi_falls == 0, "R10 sclk with cs high", m_sclk_hi_falls, 0);
    check(m_valid == 1, "R8 valid count", m_valid, 1);
    check(m_ready_at_valid == 1, "R8 ready at valid", m_ready_at_valid, 1);
    check(m_cnv_falls == 1, "R2 strobe count", m_cnv_falls, 1);
    check(m_cnv_low == CNVW, "R2 strobe width", m_cnv_low, CNVW);
    check(err == 1'b0, "R9 no error", err, 0);
    if (er) check(m_cs_busy > 0, "R4 cs during busy", m_cs_busy, 1);
    else begin
      check(m_cs_busy == 0, "R3 cs during busy", m_cs_busy, 0);
      check(m_cs_low == 2*DIV*nb, "R5 phase timing", m_cs_low, 2*DIV*nb);
    end
  endtask

  function automatic logic [RW-1:0] pat(int i);
    case (i)
      0: return '0;
      1: return '1;
      2: return {(RW/2){2'b10}};
      default: return RW'((i * 1103515 + 12345) ^ (i << 5));
    endcase
  endfunction

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(cnv_n && cs_n && sclk, "R1 idle lines", {cnv_n, cs_n, sclk}, 7);
    check(!valid && !err, "R1 flags", {valid, err}, 0);

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 6; p++)
        run_xfer(m[2], m[1], m[0], pat(p), pat(p + 7));

    for (int k = 0; k < RW; k++)
      run_xfer(1'b0, 1'b0, 1'b0, RW'(1) << k, ~(RW'(1) << k));

    // busy timeout (R9), results must be held (R8)
    begin
      logic [RW-1:0] old_a, old_b;
      old_a = res_a; old_b = res_b;
      val_a = 12'h5A5; val_b = 12'h3C3; conv_cycles = 200;
      launch(1'b0, 1'b0, 1'b0);
      check(err == 1'b1, "R9 error set", err, 1);
      check(ready == 1'b1, "R9 back to idle", ready, 1);
      check(m_valid == 0, "R9 no valid", m_valid, 0);
      check(m_sclk_falls + m_sclk_hi_falls == 0, "R9 no pulses", m_sclk_falls, 0);
      check(m_cs_low == 0, "R9 cs held high", m_cs_low, 0);
      check(res_a == old_a && res_b == old_b, "R8 results held", res_a, old_a);
      while (busy) @(posedge clk);
      repeat (4) @(posedge clk);
      run_xfer(1'b1, 1'b1, 1'b0, 12'hABC, 12'h123);
      check(err == 1'b0, "R9 error cleared", err, 0);
    end
    report();
  end
endmodule